// File: doc/BRIEF.md
# Windowed register file over shared RAM

This block is a sixteen-entry, word-wide general-purpose register file whose registers are not flops of their own. Every register is a word of one on-chip data RAM, and a base pointer held in a register chooses which sixteen consecutive words form the active bank. A register number is turned into a RAM word address by adding it to the pointer, with the sum wrapping at the top of the RAM. Changing banks therefore costs one pointer write. As many banks exist as the RAM can hold, and two banks whose bases are closer than sixteen words share words, which lets a caller and a callee pass values through common registers.

Two read ports and one write port take a register number. A further port takes a RAM word address, so the same storage can also be read and written as plain memory. Reads on all three read paths are combinational. Writes commit on the rising clock edge. When a read targets a word that a write is storing in the same cycle, the read returns the data being written. When the register write port and the memory write port both target one word in the same cycle, the register port wins.

Top module: `rbk_regbank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the base pointer output `cp_q` reads 0.
- R2: When `cp_we` is high, `cp_q` takes the value of `cp_wdata` after the next rising edge. Register reads and register writes made in the cycle of the pointer write still use the old pointer.
- R3: Register number n of the active bank is RAM word `cp_q + n`, so it can be read back through the memory port at that address.
- R4: The sum `cp_q + n` wraps modulo the RAM depth. With a depth of 1024 words and a pointer of 1020, register 7 is word 3 and register 4 is word 0.
- R5: The two register read ports are independent. Each returns, combinationally, the word selected by its own register number under the current pointer.
- R6: A register write with `rw_en` high stores `rw_data` at the rising edge. From the next cycle it is visible through either register read port.
- R7: A memory write with `mem_we` high stores `mem_wdata` at `mem_addr` at the rising edge. From the next cycle it is visible as a register whenever the active bank covers that word.
- R8: If a register write and a memory write target the same RAM word in one cycle, the word keeps the register port's data. If they target different words, both are stored.
- R9: A register read port that targets a word being written in the same cycle returns the new data. This holds whether the write comes from the register port or from the memory port.
- R10: The memory read data `mem_rdata` returns the new data when `mem_addr` equals the word being written in the same cycle, with the register port's data taking precedence.
- R11: Banks may overlap. A word written as register 12 with the pointer at 400 reads back as register 4 once the pointer is 408.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cp_we | input | 1 | Load the base pointer |
| cp_wdata | input | ADDR_W (10) | New base pointer, a RAM word address |
| cp_q | output | ADDR_W (10) | Current base pointer |
| ra_idx | input | IDX_W (4) | Register number for read port A |
| ra_data | output | DATA_W (16) | Read port A data |
| rb_idx | input | IDX_W (4) | Register number for read port B |
| rb_data | output | DATA_W (16) | Read port B data |
| rw_en | input | 1 | Register write enable |
| rw_idx | input | IDX_W (4) | Register number to write |
| rw_data | input | DATA_W (16) | Register write data |
| mem_we | input | 1 | Memory port write enable |
| mem_addr | input | ADDR_W (10) | Memory port word address, used for both reading and writing |
| mem_wdata | input | DATA_W (16) | Memory port write data |
| mem_rdata | output | DATA_W (16) | Memory port read data |

## Verification
The bench builds the block with its default values: 16 registers of 16 bits over a 1024-word RAM. A pointer placed four words below the top of that RAM makes the wrap of the register-to-word sum visible at both ports. Because the full depth is present, banks can be placed far apart, so that they are disjoint, or eight words apart, so that they overlap. The same defaults allow a register write and a memory write to be aimed at one word in the same cycle, which brings the collision rule and every forwarding path within reach.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

  // Source selected for a read path when a same-cycle write hits its word
  typedef enum logic [1:0] {
    FWD_NONE = 2'd0,
    FWD_REG  = 2'd1,
    FWD_MEM  = 2'd2
  } fwd_src_e;

endpackage

// File: rtl/rbk_xlate.sv
// Turns a register number into a RAM word address under a base pointer.
module rbk_xlate #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);

  localparam int PAD_W = ADDR_W - IDX_W;

  // Sum truncated to ADDR_W bits: wraps at the top of the RAM
  always_comb begin
    addr = base + {{PAD_W{1'b0}}, idx};
  end

endmodule

// File: rtl/rbk_wr_arb.sv
// Orders the two write sources; the register port owns a shared word.
module rbk_wr_arb #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_data,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data,
  output logic              p0_we,
  output logic [ADDR_W-1:0] p0_addr,
  output logic [DATA_W-1:0] p0_data,
  output logic              p1_we,
  output logic [ADDR_W-1:0] p1_addr,
  output logic [DATA_W-1:0] p1_data
);

  logic same_word;

  always_comb begin
    same_word = reg_we && mem_we && (reg_addr == mem_addr);
    p0_we     = reg_we;
    p0_addr   = reg_addr;
    p0_data   = reg_data;
    // The memory write is dropped when it would land on the register write's word
    p1_we     = mem_we && !same_word;
    p1_addr   = mem_addr;
    p1_data   = mem_data;
  end

endmodule

// File: rtl/rbk_fwd.sv
// Bypass for one read path: returns same-cycle write data on an address hit.
module rbk_fwd
  import rbk_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] ram_q,
  input  logic              p0_we,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_data,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_data,
  output logic [DATA_W-1:0] rd_data
);

  fwd_src_e src;

  always_comb begin
    src = FWD_NONE;
    if (p1_we && (p1_addr == rd_addr)) src = FWD_MEM;
    if (p0_we && (p0_addr == rd_addr)) src = FWD_REG;
    case (src)
      FWD_REG: rd_data = p0_data;
      FWD_MEM: rd_data = p1_data;
      default: rd_data = ram_q;
    endcase
  end

endmodule

// File: rtl/rbk_store.sv
// Word array with two write ports and NRD asynchronous read ports.
module rbk_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int NRD    = 3
) (
  input  logic              clk,
  input  logic              p0_we,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_data,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_data,
  input  logic [ADDR_W-1:0] rd_addr [NRD],
  output logic [DATA_W-1:0] rd_data [NRD]
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  // Storage is not reset; the two enables never meet on one word
  always_ff @(posedge clk) begin
    if (p0_we) words[p0_addr] <= p0_data;
    if (p1_we) words[p1_addr] <= p1_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = words[rd_addr[g]];
  end

endmodule

// File: rtl/rbk_regbank.sv
// Register bank windowed onto a shared RAM by a movable base pointer.
module rbk_regbank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int NREG   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cp_we,
  input  logic [ADDR_W-1:0]        cp_wdata,
  output logic [ADDR_W-1:0]        cp_q,
  input  logic [$clog2(NREG)-1:0]  ra_idx,
  output logic [DATA_W-1:0]        ra_data,
  input  logic [$clog2(NREG)-1:0]  rb_idx,
  output logic [DATA_W-1:0]        rb_data,
  input  logic                     rw_en,
  input  logic [$clog2(NREG)-1:0]  rw_idx,
  input  logic [DATA_W-1:0]        rw_data,
  input  logic                     mem_we,
  input  logic [ADDR_W-1:0]        mem_addr,
  input  logic [DATA_W-1:0]        mem_wdata,
  output logic [DATA_W-1:0]        mem_rdata
);

  localparam int IDX_W = $clog2(NREG);
  localparam int NRP   = 2;          // register read ports
  localparam int NRD   = NRP + 1;    // plus the memory read port
  localparam int MEM_P = NRP;        // slot of the memory read port

  // ---------------- reset release synchroniser ----------------
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // ---------------- base pointer ----------------
  logic [ADDR_W-1:0] cp_d;

  always_comb begin
    cp_d = cp_q;
    if (cp_we) cp_d = cp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   cp_q <= '0;
    else if (cp_we) cp_q <= cp_d;
  end

  // ---------------- register number to word address ----------------
  logic [IDX_W-1:0]  rp_idx  [NRP];
  logic [ADDR_W-1:0] rp_addr [NRP];
  logic [ADDR_W-1:0] rw_addr;

  assign rp_idx[0] = ra_idx;
  assign rp_idx[1] = rb_idx;

  for (genvar g = 0; g < NRP; g++) begin : g_rxl
    rbk_xlate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_xl (
      .base (cp_q),
      .idx  (rp_idx[g]),
      .addr (rp_addr[g])
    );
  end

  rbk_xlate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wxl (
    .base (cp_q),
    .idx  (rw_idx),
    .addr (rw_addr)
  );

  // ---------------- write arbitration ----------------
  logic              p0_we, p1_we;
  logic [ADDR_W-1:0] p0_addr, p1_addr;
  logic [DATA_W-1:0] p0_data, p1_data;

  rbk_wr_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .reg_we   (rw_en),
    .reg_addr (rw_addr),
    .reg_data (rw_data),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_data (mem_wdata),
    .p0_we    (p0_we),
    .p0_addr  (p0_addr),
    .p0_data  (p0_data),
    .p1_we    (p1_we),
    .p1_addr  (p1_addr),
    .p1_data  (p1_data)
  );

  // ---------------- storage ----------------
  logic [ADDR_W-1:0] rd_addr [NRD];
  logic [DATA_W-1:0] ram_q   [NRD];
  logic [DATA_W-1:0] fwd_q   [NRD];

  always_comb begin
    for (int k = 0; k < NRP; k++) rd_addr[k] = rp_addr[k];
    rd_addr[MEM_P] = mem_addr;
  end

  rbk_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NRD)) u_store (
    .clk     (clk),
    .p0_we   (p0_we),
    .p0_addr (p0_addr),
    .p0_data (p0_data),
    .p1_we   (p1_we),
    .p1_addr (p1_addr),
    .p1_data (p1_data),
    .rd_addr (rd_addr),
    .rd_data (ram_q)
  );

  // ---------------- same-cycle bypass per read path ----------------
  for (genvar g = 0; g < NRD; g++) begin : g_fwd
    rbk_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
      .rd_addr (rd_addr[g]),
      .ram_q   (ram_q[g]),
      .p0_we   (p0_we),
      .p0_addr (p0_addr),
      .p0_data (p0_data),
      .p1_we   (p1_we),
      .p1_addr (p1_addr),
      .p1_data (p1_data),
      .rd_data (fwd_q[g])
    );
  end

  assign ra_data   = fwd_q[0];
  assign rb_data   = fwd_q[1];
  assign mem_rdata = fwd_q[MEM_P];

endmodule

// File: rtl/rbk_regbank_chk.sv
// Property checker, bound into every instance of the register bank.
module rbk_regbank_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              cp_we,
  input logic [ADDR_W-1:0] cp_wdata,
  input logic [ADDR_W-1:0] cp_q,
  input logic [IDX_W-1:0]  ra_idx,
  input logic [DATA_W-1:0] ra_data,
  input logic [IDX_W-1:0]  rb_idx,
  input logic [DATA_W-1:0] rb_data,
  input logic              rw_en,
  input logic [IDX_W-1:0]  rw_idx,
  input logic [DATA_W-1:0] rw_data,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);

  localparam int PAD_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] tgt_word;
  logic              reg_owns_mem;
  assign tgt_word     = cp_q + {{PAD_W{1'b0}}, rw_idx};
  assign reg_owns_mem = rw_en && (mem_addr == tgt_word);

  assert_cp_load_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    cp_we |=> (cp_q == $past(cp_wdata)));

  assert_cp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cp_we |=> $stable(cp_q));

  assert_porta_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rw_en && (ra_idx == rw_idx)) |-> (ra_data == rw_data));

  assert_portb_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rw_en && (rb_idx == rw_idx)) |-> (rb_data == rw_data));

  assert_mem_reg_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_owns_mem |-> (mem_rdata == rw_data));

  assert_mem_own_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_we && !reg_owns_mem) |-> (mem_rdata == mem_wdata));

endmodule

bind rbk_regbank rbk_regbank_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .IDX_W  ($clog2(NREG))
) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .cp_we     (cp_we),
  .cp_wdata  (cp_wdata),
  .cp_q      (cp_q),
  .ra_idx    (ra_idx),
  .ra_data   (ra_data),
  .rb_idx    (rb_idx),
  .rb_data   (rb_data),
  .rw_en     (rw_en),
  .rw_idx    (rw_idx),
  .rw_data   (rw_data),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata)
);

// File: tb/tb_rbk_regbank.sv
module tb_rbk_regbank;

  localparam int DW = 16;
  localparam int AW = 10;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cp_we;
  logic [AW-1:0] cp_wdata;
  logic [AW-1:0] cp_q;
  logic [IW-1:0] ra_idx, rb_idx, rw_idx;
  logic [DW-1:0] ra_data, rb_data, rw_data;
  logic          rw_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;   // 50 MHz

  rbk_regbank #(.DATA_W(DW), .ADDR_W(AW), .NREG(16)) dut (
    .clk (clk), .rst_n (rst_n),
    .cp_we (cp_we), .cp_wdata (cp_wdata), .cp_q (cp_q),
    .ra_idx (ra_idx), .ra_data (ra_data),
    .rb_idx (rb_idx), .rb_data (rb_data),
    .rw_en (rw_en), .rw_idx (rw_idx), .rw_data (rw_data),
    .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
  );

  // ---------------- scoreboard ----------------
  string         q_req [$];
  int            q_port[$];
  logic [DW-1:0] q_exp [$];
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            done    = 1'b0;

  // reference contents, written only from the requirements
  logic [DW-1:0] ref_mem [1 << AW];
  logic [AW-1:0] ref_cp;

  // port codes: 0 ra_data, 1 rb_data, 2 mem_rdata, 3 cp_q
  task automatic expect_val(input string req, input int port, input logic [DW-1:0] v);
    q_req.push_back(req);
    q_port.push_back(port);
    q_exp.push_back(v);
  endtask

  string         m_req;
  int            m_port;
  logic [DW-1:0] m_exp, m_act;

  always @(negedge clk) begin
    while (q_req.size() > 0) begin
      m_req  = q_req.pop_front();
      m_port = q_port.pop_front();
      m_exp  = q_exp.pop_front();
      case (m_port)
        0:       m_act = ra_data;
        1:       m_act = rb_data;
        2:       m_act = mem_rdata;
        default: m_act = {{(DW-AW){1'b0}}, cp_q};
      endcase
      n_tests++;
      if (m_act !== m_exp) begin
        n_fail++;
        $display("FAIL %s port %0d actual %h expected %h", m_req, m_port, m_act, m_exp);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic idle();
    cp_we = 1'b0; cp_wdata = '0;
    ra_idx = '0; rb_idx = '0;
    rw_en = 1'b0; rw_idx = '0; rw_data = '0;
    mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
  endtask

  task automatic tick();
    logic [AW-1:0] wa;
    @(posedge clk);
    wa = ref_cp + {{(AW-IW){1'b0}}, rw_idx};
    if (rw_en) ref_mem[wa] = rw_data;
    if (mem_we && !(rw_en && (mem_addr == wa))) ref_mem[mem_addr] = mem_wdata;
    if (cp_we) ref_cp = cp_wdata;
    #1;
    idle();
  endtask

  function automatic logic [DW-1:0] rget(input int n);
    logic [AW-1:0] a;
    a = ref_cp + AW'(n);
    return ref_mem[a];
  endfunction

  task automatic set_cp(input logic [AW-1:0] v);
    cp_we = 1'b1; cp_wdata = v;
    tick();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    idle();
    ref_cp = '0;
    rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    expect_val("R1 pointer in reset", 3, 16'h0000);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    expect_val("R1 pointer after release", 3, 16'h0000);
    tick();

    // R2: pointer load appears after the edge
    cp_we = 1'b1; cp_wdata = 10'd100;
    expect_val("R2 old pointer in load cycle", 3, 16'd0);
    tick();
    expect_val("R2 pointer loaded", 3, 16'd100);
    tick();

    // R6: fill bank at 100
    for (int i = 0; i < 16; i++) begin
      rw_en = 1'b1; rw_idx = IW'(i); rw_data = 16'h1000 + DW'(i * 17);
      tick();
    end
    // R3 / R5: read back by register and by word address
    for (int i = 0; i < 16; i++) begin
      mem_addr = 10'd100 + AW'(i);
      ra_idx = IW'(i);
      rb_idx = IW'(15 - i);
      expect_val("R3 register n at word base+n", 2, 16'h1000 + DW'(i * 17));
      expect_val("R6 written register on port A", 0, rget(i));
      expect_val("R5 port B independent", 1, rget(15 - i));
      tick();
    end

    // R4: wrap at the top of the RAM
    set_cp(10'd1020);
    rw_en = 1'b1; rw_idx = 4'd7; rw_data = 16'hBEEF;
    tick();
    rw_en = 1'b1; rw_idx = 4'd4; rw_data = 16'h0F0F;
    tick();
    mem_addr = 10'd3; ra_idx = 4'd7; rb_idx = 4'd4;
    expect_val("R4 register 7 is word 3", 2, 16'hBEEF);
    expect_val("R4 register 7 on port A", 0, 16'hBEEF);
    expect_val("R4 register 4 on port B", 1, 16'h0F0F);
    tick();
    mem_addr = 10'd0;
    expect_val("R4 register 4 is word 0", 2, 16'h0F0F);
    tick();

    // R7 / R9: memory write seen as a register
    mem_we = 1'b1; mem_addr = 10'd1021; mem_wdata = 16'h5A5A;
    ra_idx = 4'd1; rb_idx = 4'd2;
    expect_val("R9 memory write bypassed to port A", 0, 16'h5A5A);
    expect_val("R10 memory write bypassed to memory read", 2, 16'h5A5A);
    expect_val("R9 unrelated register not bypassed", 1, rget(2));
    tick();
    ra_idx = 4'd1;
    expect_val("R7 memory write visible as register", 0, 16'h5A5A);
    tick();

    // R8: same-word collision
    set_cp(10'd200);
    rw_en = 1'b1; rw_idx = 4'd5; rw_data = 16'hAAAA;
    mem_we = 1'b1; mem_addr = 10'd205; mem_wdata = 16'h5555;
    ra_idx = 4'd5;
    expect_val("R8 collision port A sees register data", 0, 16'hAAAA);
    expect_val("R10 collision memory read sees register data", 2, 16'hAAAA);
    tick();
    mem_addr = 10'd205;
    expect_val("R8 collision stored register data", 2, 16'hAAAA);
    tick();
    rw_en = 1'b1; rw_idx = 4'd6; rw_data = 16'h1111;
    mem_we = 1'b1; mem_addr = 10'd210; mem_wdata = 16'h2222;
    tick();
    ra_idx = 4'd6; rb_idx = 4'd10;
    expect_val("R8 distinct words both stored (register)", 0, 16'h1111);
    expect_val("R8 distinct words both stored (memory)", 1, 16'h2222);
    tick();

    // R9 / R10: register write bypassed to all three paths
    rw_en = 1'b1; rw_idx = 4'd9; rw_data = 16'hC0DE;
    ra_idx = 4'd9; rb_idx = 4'd9; mem_addr = 10'd209;
    expect_val("R9 register write bypassed to port A", 0, 16'hC0DE);
    expect_val("R9 register write bypassed to port B", 1, 16'hC0DE);
    expect_val("R10 register write bypassed to memory read", 2, 16'hC0DE);
    tick();

    // R2: write in the pointer-load cycle uses the old bank
    mem_we = 1'b1; mem_addr = 10'd302; mem_wdata = 16'h7777;
    tick();
    cp_we = 1'b1; cp_wdata = 10'd300;
    rw_en = 1'b1; rw_idx = 4'd2; rw_data = 16'h3333;
    ra_idx = 4'd2;
    expect_val("R2 load cycle read uses old bank", 0, 16'h3333);
    tick();
    ra_idx = 4'd2; mem_addr = 10'd202;
    expect_val("R2 new bank register 2 is word 302", 0, 16'h7777);
    expect_val("R2 load cycle write landed in old bank", 2, 16'h3333);
    tick();

    // R11: overlapping banks
    set_cp(10'd400);
    rw_en = 1'b1; rw_idx = 4'd12; rw_data = 16'h4242;
    tick();
    set_cp(10'd408);
    ra_idx = 4'd4;
    expect_val("R11 shared word through overlapping bank", 0, 16'h4242);
    tick();

    repeat (2) tick();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule